// File: doc/BRIEF.md
# FFT Stream to FIFO Bridge

This block joins two simple word FIFOs to a streaming FFT engine that uses valid/ready handshakes. On the way in it pulls 32-bit samples from a FIFO read port (data, a word-available flag and a read strobe) and hands them to the engine. It counts the samples and raises the end-of-frame marker on the last sample of each 256-point frame.

On the way back it accepts the engine's complex results. The real part sits in the upper half of each word and the imaginary part in the lower half. For a real-valued input the upper half of the spectrum mirrors the lower half. The bridge therefore writes only the first 128 results of each frame into the output FIFO and silently consumes the other 128. The output FIFO can stall the engine only while the bridge is keeping words.

The result counter restarts on every accepted end-of-frame marker. A marker that arrives anywhere but the final index sets a sticky error flag, which only reset clears.

Top module: `fft_fifo_bridge`

## Requirements
- R1: `fftInData` always equals `inData`, and `fftInValid` always equals `inExists`.
- R2: `inRead` is high in exactly those cycles where `inExists` and `fftInReady` are both high, so one FIFO word is consumed per sample transfer.
- R3: `fftInLast` is high exactly while the pending sample is the 256th transfer of its frame (index 255, counting from 0 after reset). The count advances only on a transfer and wraps to 0 after index 255.
- R4: `outData` always equals `fftOutData`, keeping the real part in bits 31:16 and the imaginary part in bits 15:0.
- R5: For result indices 0 to 127, `fftOutReady` equals the inverse of `outFull`, and `outWrite` is high exactly when `fftOutValid` is high and `outFull` is low.
- R6: For result indices 128 to 255, `fftOutReady` is high and `outWrite` is low, whatever `outFull` and `fftOutValid` are.
- R7: The result index advances by one on each accepted result (valid and ready high at the same edge). It returns to 0 after an accepted result that carries `fftOutLast`.
- R8: `errFlag` is set when a result with `fftOutLast` is accepted at any index other than 255. Once set, it stays high until reset. An end marker accepted at index 255 leaves it low.
- R9: After reset both indices are 0 and `errFlag` is low. With `inExists` and `fftOutValid` low, `inRead` and `outWrite` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 32 | Sample word from the input FIFO |
| inExists | input | 1 | Input FIFO holds a word |
| inRead | output | 1 | Pop strobe to the input FIFO |
| fftInData | output | 32 | Sample to the FFT engine |
| fftInValid | output | 1 | Sample valid to the engine |
| fftInReady | input | 1 | Engine accepts a sample |
| fftInLast | output | 1 | Last sample of a frame |
| fftOutData | input | 32 | Complex result, real in 31:16, imaginary in 15:0 |
| fftOutValid | input | 1 | Result valid from the engine |
| fftOutReady | output | 1 | Bridge accepts a result |
| fftOutLast | input | 1 | Last result of a frame |
| outData | output | 32 | Word to the output FIFO |
| outFull | input | 1 | Output FIFO cannot take a word |
| outWrite | output | 1 | Push strobe to the output FIFO |
| errFlag | output | 1 | Sticky misplaced end-of-frame flag |

## Verification
The sample side and the result side run independently, so an input transfer, with its count or end-marker update, can fall in the same cycle as a result being kept or dropped. The bench drives both sides in one loop. Each side uses its own periodic availability and back-pressure pattern with coprime periods, so every combination of simultaneous transfers, stalls and full conditions occurs across two full frames on each side. In every cycle, the bench judges each side against its own arithmetic index model. The model advances only on handshakes that the bench predicts from the requirements. A misplaced end marker is then injected to check the error flag and the restart of the index.

// File: rtl/fft_bridge_pkg.sv
package fft_bridge_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic markLast;   // pending sample closes the frame
    logic dropWord;   // current result index lies in the mirrored half
  } ctrlT;

  // handshake events from datapath to control
  typedef struct packed {
    logic inXfer;
    logic outXfer;
    logic outLast;
  } xferT;

endpackage

// File: rtl/fft_bridge_ctrl.sv
module fft_bridge_ctrl
  import fft_bridge_pkg::*;
#(
  parameter int FRAME_LEN = 256
) (
  input  logic clk,
  input  logic rstN,
  input  xferT xfer,
  output ctrlT ctrl,
  output logic errFlag
);
  localparam int CNT_W    = $clog2(FRAME_LEN);
  localparam int KEEP_LEN = FRAME_LEN / 2;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] KEEP_IDX = CNT_W'(KEEP_LEN);

  logic [CNT_W-1:0] inCnt;
  logic [CNT_W-1:0] outCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inCnt <= '0;
    end else if (xfer.inXfer) begin
      inCnt <= (inCnt == LAST_IDX) ? '0 : inCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCnt  <= '0;
      errFlag <= 1'b0;
    end else if (xfer.outXfer) begin
      if (xfer.outLast) begin
        outCnt <= '0;
        if (outCnt != LAST_IDX) errFlag <= 1'b1;
      end else begin
        outCnt <= (outCnt == LAST_IDX) ? '0 : outCnt + 1'b1;
      end
    end
  end

  always_comb begin
    ctrl.markLast = (inCnt == LAST_IDX);
    ctrl.dropWord = (outCnt >= KEEP_IDX);
  end

  assert_in_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (xfer.inXfer && ctrl.markLast) |=> (inCnt == '0));
  assert_in_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !xfer.inXfer |=> $stable(inCnt));
  assert_out_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    (xfer.outXfer && xfer.outLast) |=> (outCnt == '0));
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

endmodule

// File: rtl/fft_bridge_dp.sv
module fft_bridge_dp
  import fft_bridge_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              ctrl,
  output xferT              xfer,
  input  logic [DATA_W-1:0] inData,
  input  logic              inExists,
  output logic              inRead,
  output logic [DATA_W-1:0] fftInData,
  output logic              fftInValid,
  input  logic              fftInReady,
  output logic              fftInLast,
  input  logic [DATA_W-1:0] fftOutData,
  input  logic              fftOutValid,
  output logic              fftOutReady,
  input  logic              fftOutLast,
  output logic [DATA_W-1:0] outData,
  input  logic              outFull,
  output logic              outWrite
);

  always_comb begin
    fftInData   = inData;
    fftInValid  = inExists;
    fftInLast   = ctrl.markLast;
    inRead      = inExists && fftInReady;
    outData     = fftOutData;
    fftOutReady = ctrl.dropWord || !outFull;
    outWrite    = fftOutValid && !ctrl.dropWord && !outFull;
    xfer.inXfer  = inRead;
    xfer.outXfer = fftOutValid && fftOutReady;
    xfer.outLast = fftOutLast;
  end

  assert_read_gated_R2: assert property (@(posedge clk) disable iff (!rstN)
    inRead |-> (inExists && fftInReady));
  assert_no_write_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    outWrite |-> (!outFull && fftOutValid));
  assert_drop_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.dropWord |-> (!outWrite && fftOutReady));

endmodule

// File: rtl/fft_fifo_bridge.sv
module fft_fifo_bridge
  import fft_bridge_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int FRAME_LEN = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inExists,
  output logic              inRead,
  output logic [DATA_W-1:0] fftInData,
  output logic              fftInValid,
  input  logic              fftInReady,
  output logic              fftInLast,
  input  logic [DATA_W-1:0] fftOutData,
  input  logic              fftOutValid,
  output logic              fftOutReady,
  input  logic              fftOutLast,
  output logic [DATA_W-1:0] outData,
  input  logic              outFull,
  output logic              outWrite,
  output logic              errFlag
);

  ctrlT ctrl;
  xferT xfer;

  fft_bridge_ctrl #(.FRAME_LEN(FRAME_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .xfer(xfer), .ctrl(ctrl), .errFlag(errFlag)
  );

  fft_bridge_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .xfer(xfer),
    .inData(inData), .inExists(inExists), .inRead(inRead),
    .fftInData(fftInData), .fftInValid(fftInValid),
    .fftInReady(fftInReady), .fftInLast(fftInLast),
    .fftOutData(fftOutData), .fftOutValid(fftOutValid),
    .fftOutReady(fftOutReady), .fftOutLast(fftOutLast),
    .outData(outData), .outFull(outFull), .outWrite(outWrite)
  );

endmodule

// File: tb/fft_fifo_bridge_tb.sv
module fft_fifo_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] inData = '0;
  logic        inExists = 1'b0;
  logic        inRead;
  logic [31:0] fftInData;
  logic        fftInValid;
  logic        fftInReady = 1'b0;
  logic        fftInLast;
  logic [31:0] fftOutData = '0;
  logic        fftOutValid = 1'b0;
  logic        fftOutReady;
  logic        fftOutLast = 1'b0;
  logic [31:0] outData;
  logic        outFull = 1'b0;
  logic        outWrite;
  logic        errFlag;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fft_fifo_bridge dut_i (
    .clk(clk), .rstN(rstN), .inData(inData), .inExists(inExists),
    .inRead(inRead), .fftInData(fftInData), .fftInValid(fftInValid),
    .fftInReady(fftInReady), .fftInLast(fftInLast),
    .fftOutData(fftOutData), .fftOutValid(fftOutValid),
    .fftOutReady(fftOutReady), .fftOutLast(fftOutLast),
    .outData(outData), .outFull(outFull), .outWrite(outWrite),
    .errFlag(errFlag)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int iDone = 0, oDone = 0, iIdx = 0, oIdx = 0;
    bit expRdy, expWr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    // R9 reset state
    check(errFlag == 1'b0, "R9 errFlag", 32'(errFlag), 0);
    check(inRead == 1'b0, "R9 inRead", 32'(inRead), 0);
    check(outWrite == 1'b0, "R9 outWrite", 32'(outWrite), 0);
    check(fftInLast == 1'b0, "R9 fftInLast", 32'(fftInLast), 0);

    // both sides concurrently, two frames each
    for (int cyc = 0; iDone < 512 || oDone < 512; cyc++) begin
      @(negedge clk);
      inExists    = ((cyc % 3) != 0) && (iDone < 512);
      fftInReady  = (cyc % 5) != 1;
      inData      = 32'hA500_0000 ^ (32'(cyc) * 32'h0000_9E37);
      fftOutValid = ((cyc % 4) != 2) && (oDone < 512);
      outFull     = (cyc % 7) == 3;
      fftOutLast  = (oIdx == 255);
      fftOutData  = {16'(cyc), ~16'(cyc)};
      #2;
      check(fftInData == inData, "R1 data", fftInData, inData);
      check(fftInValid == inExists, "R1 valid", 32'(fftInValid), 32'(inExists));
      check(inRead == (inExists && fftInReady), "R2 inRead", 32'(inRead),
            32'(inExists && fftInReady));
      check(fftInLast == (iIdx == 255), "R3 fftInLast", 32'(fftInLast),
            32'(iIdx == 255));
      check(outData == fftOutData, "R4 outData", outData, fftOutData);
      expRdy = (oIdx >= 128) ? 1'b1 : !outFull;
      expWr  = (oIdx < 128) && fftOutValid && !outFull;
      if (oIdx < 128) begin
        check(fftOutReady == expRdy, "R5 ready", 32'(fftOutReady), 32'(expRdy));
        check(outWrite == expWr, "R5 write", 32'(outWrite), 32'(expWr));
      end else begin
        check(fftOutReady == 1'b1, "R6 ready", 32'(fftOutReady), 1);
        check(outWrite == 1'b0, "R6 write", 32'(outWrite), 0);
      end
      if (inExists && fftInReady) begin
        iDone++;
        iIdx = (iIdx + 1) % 256;
      end
      if (fftOutValid && expRdy) begin
        oDone++;
        oIdx = (oIdx == 255) ? 0 : oIdx + 1;
      end
    end

    @(negedge clk);
    inExists = 0; fftOutValid = 0; outFull = 0; fftOutLast = 0;
    #2;
    check(errFlag == 1'b0, "R8 no error on proper end", 32'(errFlag), 0);

    // misplaced end marker at index 10
    for (int k = 0; k < 11; k++) begin
      @(negedge clk);
      fftOutValid = 1; fftOutLast = (k == 10);
    end
    @(negedge clk);
    fftOutValid = 0; fftOutLast = 0;
    #2;
    check(errFlag == 1'b1, "R8 early end sets flag", 32'(errFlag), 1);

    // index must have restarted: 128 kept, then the 129th dropped
    for (int k = 0; k < 129; k++) begin
      @(negedge clk);
      fftOutValid = 1; outFull = 0;
      #2;
      check(outWrite == (k < 128), "R7 restart index", 32'(outWrite), 32'(k < 128));
    end
    @(negedge clk);
    fftOutValid = 0;
    #2;
    check(errFlag == 1'b1, "R8 flag sticky", 32'(errFlag), 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule